// File: doc/BRIEF.md
# Serial Flash Write-Protection Guard

This block holds the protection state of a serial flash device and rules on every state-changing command that reaches it. The state is a sticky lock bit, a three-bit protected-area selector and a write-enable latch. A status write is gated by the latch, the lock bit and an active-low write-protect pin. Program and erase requests are gated by the latch and by the address range that the selector fences off at the top of the array.

Commands arrive already decoded, as single-cycle strobes sampled on the rising clock edge. Verdicts come back as one-cycle accept or reject pulses in the following cycle, together with the updated status byte. A two-bit mode output follows the pin with no register in between, so a change of the pin shows up at once. Serial shifting and the storage array are not part of this block.

Top module: `wp_flash_guard`

## Requirements
- R1: A synchronous active-high reset clears the status byte to 0x00, drops all four verdict pulses and makes the mode output 2'b00 (unprotected).
- R2: The write-enable latch reads back in status bit 1. The enable strobe sets it, the disable strobe clears it, and any status-write, program, sector-erase or bulk-erase strobe clears it one cycle later, whether that command was accepted or rejected.
- R3: While the lock bit (status bit 7) is 0, a status write is accepted if and only if the latch is set, at either pin level. An accepted write copies the lock input into bit 7 and the area selector input into bits 4:2. Bits 6, 5 and 0 always read 0.
- R4: While the lock bit is 1 and the write-protect pin is high, a status write is accepted if and only if the latch is set.
- R5: While the lock bit is 1 and the pin is low, every status write is rejected, even with the latch set, and bits 7 and 4:2 keep their values.
- R6: The mode output is 2'b10 (hardware-protected) exactly when the lock bit is 1 and the pin is low. This holds whether the lock was set while the pin was already low or the pin fell after the lock was set. Otherwise the mode is 2'b01 when the selector is nonzero and 2'b00 when it is zero.
- R7: Hardware-protected mode is left only by driving the pin high. The mode output leaves 2'b10 in the same cycle, with no clock edge needed.
- R8: The selector picks the protected span at the top of a 2^20-byte space. Value 0 protects nothing. Value k from 1 to 6 protects the top 2^(13+k) bytes, which is 1/64 doubling up to 1/2. Value 7 protects every address.
- R9: With the latch set, a page program or sector erase is accepted at addresses outside the protected span and rejected inside it.
- R10: A bulk erase is rejected whenever the selector is nonzero. With the selector zero it is accepted if the latch is set.
- R11: Any program or erase request made while the latch is clear is rejected.
- R12: Status-write verdicts (accept/reject) and program/erase verdicts (accept/reject) each appear as exactly one one-cycle pulse in the cycle after their command, and never without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| prog_i | input | 1 | Page-program request strobe |
| serase_i | input | 1 | Sector-erase request strobe |
| berase_i | input | 1 | Bulk-erase request strobe |
| wp_n_i | input | 1 | Write-protect pin, active low |
| wr_lock_i | input | 1 | New lock bit carried by a status write |
| wr_bp_i | input | 3 | New area selector carried by a status write |
| addr_i | input | ADDR_W | Target byte address of a program or sector erase |
| status_o | output | 8 | Status byte: bit 7 lock, bits 4:2 selector, bit 1 latch |
| wr_acc_o | output | 1 | Status write accepted (pulse) |
| wr_rej_o | output | 1 | Status write rejected (pulse) |
| op_acc_o | output | 1 | Program/erase accepted (pulse) |
| op_rej_o | output | 1 | Program/erase rejected (pulse) |
| mode_o | output | 2 | 00 unprotected, 01 software-protected, 10 hardware-protected |

## Verification
The properties assume that at most one command strobe is high in any cycle, because the latch update and the verdict pairing are defined for a single command. The bench drives exactly one strobe or none per cycle, in both its directed and random phases. It changes the pin and the data inputs only at falling edges, so every property sees stable inputs at the sampling edge.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam int BP_W     = 3;
    localparam int STAT_W   = 8;
    localparam int LEVELS   = 1 << BP_W;

    typedef enum logic [1:0] {
        MODE_OPEN = 2'b00,
        MODE_SOFT = 2'b01,
        MODE_HARD = 2'b10
    } guard_mode_e;

    typedef struct packed {
        logic            lock;
        logic [BP_W-1:0] bp;
        logic            wel;
    } guard_state_t;

    typedef struct packed {
        logic wren;
        logic wrdi;
        logic wrsr;
        logic prog;
        logic serase;
        logic berase;
    } guard_cmd_t;

    typedef struct packed {
        logic ok;
        logic rej;
    } verdict_t;

    function automatic logic [STAT_W-1:0] pack_status(input guard_state_t s);
        return {s.lock, 2'b00, s.bp, s.wel, 1'b0};
    endfunction

    function automatic guard_mode_e mode_of(input guard_state_t s, input logic wp_n);
        if (s.lock && !wp_n)
            return MODE_HARD;
        else if (s.bp != '0)
            return MODE_SOFT;
        else
            return MODE_OPEN;
    endfunction

    function automatic logic is_mutating(input guard_cmd_t c);
        return c.wrsr | c.prog | c.serase | c.berase;
    endfunction

endpackage

// File: rtl/wp_region_map.sv
module wp_region_map
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic [BP_W-1:0]   bp,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit,
    output logic              any
);
    // Level k (1..LEVELS-2) fences off the top 2^(ADDR_W-(LEVELS-1)+k) bytes:
    // the address is inside when its top (LEVELS-1-k) bits are all ones.
    localparam int TOP_LVL = LEVELS - 1;

    logic [LEVELS-1:0] lvl_hit;

    assign lvl_hit[0]       = 1'b0;
    assign lvl_hit[TOP_LVL] = 1'b1;

    generate
        for (genvar k = 1; k < TOP_LVL; k++) begin : g_lvl
            localparam int NBITS = TOP_LVL - k;
            assign lvl_hit[k] = &addr[ADDR_W-1 -: NBITS];
        end
    endgenerate

    assign hit = lvl_hit[bp];
    assign any = (bp != '0);

endmodule

// File: rtl/wp_cmd_eval.sv
module wp_cmd_eval
    import wp_guard_pkg::*;
(
    input  guard_cmd_t      cmd,
    input  guard_state_t    cur,
    input  logic            wp_n,
    input  logic            new_lock,
    input  logic [BP_W-1:0] new_bp,
    input  logic            area_hit,
    input  logic            area_any,
    output guard_state_t    nxt,
    output verdict_t        wr_v,
    output verdict_t        op_v
);
    logic hw_locked;
    logic wr_go;
    logic is_op;
    logic op_blocked;
    logic op_go;

    always_comb begin
        hw_locked  = cur.lock & ~wp_n;
        wr_go      = cmd.wrsr & cur.wel & ~hw_locked;
        is_op      = cmd.prog | cmd.serase | cmd.berase;
        op_blocked = cmd.berase ? area_any : area_hit;
        op_go      = is_op & cur.wel & ~op_blocked;

        wr_v.ok  = wr_go;
        wr_v.rej = cmd.wrsr & ~wr_go;
        op_v.ok  = op_go;
        op_v.rej = is_op & ~op_go;

        nxt = cur;
        if (wr_go) begin
            nxt.lock = new_lock;
            nxt.bp   = new_bp;
        end
        if (is_mutating(cmd))
            nxt.wel = 1'b0;
        else if (cmd.wren)
            nxt.wel = 1'b1;
        else if (cmd.wrdi)
            nxt.wel = 1'b0;
    end

endmodule

// File: rtl/wp_state_reg.sv
module wp_state_reg
    import wp_guard_pkg::*;
(
    input  logic         clk,
    input  logic         rst,
    input  guard_state_t nxt,
    input  verdict_t     wr_v_in,
    input  verdict_t     op_v_in,
    output guard_state_t cur,
    output verdict_t     wr_v_q,
    output verdict_t     op_v_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cur    <= '0;
            wr_v_q <= '0;
            op_v_q <= '0;
        end else begin
            cur    <= nxt;
            wr_v_q <= wr_v_in;
            op_v_q <= op_v_in;
        end
    end

endmodule

// File: rtl/wp_flash_guard.sv
module wp_flash_guard
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 20
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wren_i,
    input  logic              wrdi_i,
    input  logic              wrsr_i,
    input  logic              prog_i,
    input  logic              serase_i,
    input  logic              berase_i,
    input  logic              wp_n_i,
    input  logic              wr_lock_i,
    input  logic [2:0]        wr_bp_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic [7:0]        status_o,
    output logic              wr_acc_o,
    output logic              wr_rej_o,
    output logic              op_acc_o,
    output logic              op_rej_o,
    output logic [1:0]        mode_o
);
    guard_cmd_t   cmd;
    guard_state_t cur;
    guard_state_t nxt;
    verdict_t     wr_v;
    verdict_t     op_v;
    verdict_t     wr_q;
    verdict_t     op_q;
    logic         area_hit;
    logic         area_any;

    assign cmd = '{wren: wren_i, wrdi: wrdi_i, wrsr: wrsr_i,
                   prog: prog_i, serase: serase_i, berase: berase_i};

    wp_region_map #(.ADDR_W(ADDR_W)) u_region (
        .bp   (cur.bp),
        .addr (addr_i),
        .hit  (area_hit),
        .any  (area_any)
    );

    wp_cmd_eval u_eval (
        .cmd      (cmd),
        .cur      (cur),
        .wp_n     (wp_n_i),
        .new_lock (wr_lock_i),
        .new_bp   (wr_bp_i),
        .area_hit (area_hit),
        .area_any (area_any),
        .nxt      (nxt),
        .wr_v     (wr_v),
        .op_v     (op_v)
    );

    wp_state_reg u_state (
        .clk     (clk),
        .rst     (rst),
        .nxt     (nxt),
        .wr_v_in (wr_v),
        .op_v_in (op_v),
        .cur     (cur),
        .wr_v_q  (wr_q),
        .op_v_q  (op_q)
    );

    assign status_o = pack_status(cur);
    assign wr_acc_o = wr_q.ok;
    assign wr_rej_o = wr_q.rej;
    assign op_acc_o = op_q.ok;
    assign op_rej_o = op_q.rej;
    assign mode_o   = mode_of(cur, wp_n_i);

endmodule

// File: rtl/wp_flash_guard_chk.sv
module wp_flash_guard_chk (
    input logic       clk,
    input logic       rst,
    input logic       wren_i,
    input logic       wrdi_i,
    input logic       wrsr_i,
    input logic       prog_i,
    input logic       serase_i,
    input logic       berase_i,
    input logic       wp_n_i,
    input logic [7:0] status_o,
    input logic       wr_acc_o,
    input logic       wr_rej_o,
    input logic       op_acc_o,
    input logic       op_rej_o,
    input logic [1:0] mode_o
);
    logic mut;
    logic op;
    assign op  = prog_i | serase_i | berase_i;
    assign mut = wrsr_i | op;

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (status_o == 8'h00 && !wr_acc_o && !wr_rej_o && !op_acc_o && !op_rej_o)); // R1

    AST_WEL_DROP: assert property (@(posedge clk) disable iff (rst)
        mut |=> !status_o[1]); // R2

    AST_WEL_SET: assert property (@(posedge clk) disable iff (rst)
        (wren_i && !mut) |=> status_o[1]); // R2

    AST_HPM_HOLD: assert property (@(posedge clk) disable iff (rst)
        (wrsr_i && status_o[7] && !wp_n_i) |=>
            (wr_rej_o && status_o[7:2] == $past(status_o[7:2]))); // R5

    AST_OPEN_WRITE: assert property (@(posedge clk) disable iff (rst)
        (wrsr_i && !status_o[7] && status_o[1]) |=> wr_acc_o); // R3

    AST_HW_MODE: assert property (@(posedge clk) disable iff (rst)
        (mode_o == 2'b10) |-> (status_o[7] && !wp_n_i)); // R6

    AST_PIN_EXIT: assert property (@(posedge clk) disable iff (rst)
        wp_n_i |-> (mode_o != 2'b10)); // R7

    AST_BULK_GUARD: assert property (@(posedge clk) disable iff (rst)
        (berase_i && status_o[4:2] != 3'b000) |=> (op_rej_o && !op_acc_o)); // R10

    AST_NO_WEL_OP: assert property (@(posedge clk) disable iff (rst)
        (op && !status_o[1]) |=> op_rej_o); // R11

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wr_acc_o, wr_rej_o}) && $onehot0({op_acc_o, op_rej_o})); // R12

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
        !mut |=> !(wr_acc_o || wr_rej_o || op_acc_o || op_rej_o)); // R12

endmodule

bind wp_flash_guard wp_flash_guard_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .wren_i   (wren_i),
    .wrdi_i   (wrdi_i),
    .wrsr_i   (wrsr_i),
    .prog_i   (prog_i),
    .serase_i (serase_i),
    .berase_i (berase_i),
    .wp_n_i   (wp_n_i),
    .status_o (status_o),
    .wr_acc_o (wr_acc_o),
    .wr_rej_o (wr_rej_o),
    .op_acc_o (op_acc_o),
    .op_rej_o (op_rej_o),
    .mode_o   (mode_o)
);

// File: tb/wp_flash_guard_tb.sv
module wp_flash_guard_tb;
    localparam int CLK_PERIOD = 10;
    localparam int AW         = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wren_i = 0, wrdi_i = 0, wrsr_i = 0;
    logic          prog_i = 0, serase_i = 0, berase_i = 0;
    logic          wp_n_i = 1'b1;
    logic          wr_lock_i = 0;
    logic [2:0]    wr_bp_i = '0;
    logic [AW-1:0] addr_i = '0;
    logic [7:0]    status_o;
    logic          wr_acc_o, wr_rej_o, op_acc_o, op_rej_o;
    logic [1:0]    mode_o;

    int n_checks = 0;
    int n_fail   = 0;

    // reference model state
    bit m_lock, m_wel;
    int m_bp;
    bit m_wok, m_wrej, m_ook, m_orej;

    always #(CLK_PERIOD/2) clk = ~clk;

    wp_flash_guard #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst(rst),
        .wren_i(wren_i), .wrdi_i(wrdi_i), .wrsr_i(wrsr_i),
        .prog_i(prog_i), .serase_i(serase_i), .berase_i(berase_i),
        .wp_n_i(wp_n_i), .wr_lock_i(wr_lock_i), .wr_bp_i(wr_bp_i),
        .addr_i(addr_i), .status_o(status_o),
        .wr_acc_o(wr_acc_o), .wr_rej_o(wr_rej_o),
        .op_acc_o(op_acc_o), .op_rej_o(op_rej_o), .mode_o(mode_o)
    );

    // R8: span size by selector, in bytes
    function automatic bit in_span(int bp, int a);
        int size;
        if (bp == 0) size = 0;
        else if (bp == 7) size = 1 << AW;
        else size = 1 << (13 + bp);
        return a >= ((1 << AW) - size);
    endfunction

    function automatic int exp_mode();
        if (m_lock && !wp_n_i) return 2;
        if (m_bp != 0) return 1;
        return 0;
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // c: 0 idle, 1 wren, 2 wrdi, 3 wrsr, 4 program, 5 sector erase, 6 bulk erase
    task automatic cyc(input int c, input bit lk, input int bp, input int a, input string tag);
        bit mut, locked, go, blocked;
        wren_i = (c == 1); wrdi_i = (c == 2); wrsr_i = (c == 3);
        prog_i = (c == 4); serase_i = (c == 5); berase_i = (c == 6);
        wr_lock_i = lk; wr_bp_i = bp[2:0]; addr_i = a[AW-1:0];
        #1;
        check(tag, "mode(now)", int'(mode_o), exp_mode()); // R6 R7
        @(posedge clk);
        // model update
        m_wok = 0; m_wrej = 0; m_ook = 0; m_orej = 0;
        if (rst) begin
            m_lock = 0; m_wel = 0; m_bp = 0;
        end else begin
            mut = (c >= 3);
            if (c == 3) begin
                locked = m_lock && !wp_n_i;
                go = m_wel && !locked;
                m_wok = go; m_wrej = !go;
                if (go) begin m_lock = lk; m_bp = bp; end
            end
            if (c >= 4) begin
                blocked = (c == 6) ? (m_bp != 0) : in_span(m_bp, a);
                go = m_wel && !blocked;
                m_ook = go; m_orej = !go;
            end
            if (mut) m_wel = 0;
            else if (c == 1) m_wel = 1;
            else if (c == 2) m_wel = 0;
        end
        @(negedge clk);
        check(tag, "status", int'(status_o),
              (int'(m_lock) << 7) | (m_bp << 2) | (int'(m_wel) << 1));
        check(tag, "wr_acc", int'(wr_acc_o), int'(m_wok));
        check(tag, "wr_rej", int'(wr_rej_o), int'(m_wrej));
        check(tag, "op_acc", int'(op_acc_o), int'(m_ook));
        check(tag, "op_rej", int'(op_rej_o), int'(m_orej));
        check(tag, "mode", int'(mode_o), exp_mode());
    endtask

    task automatic set_sr(input bit lk, input int bp);
        cyc(1, 0, 0, 0, "R2");
        cyc(3, lk, bp, 0, "R3");
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : main
        int bnd;
        @(negedge clk);
        // R1: reset state
        cyc(0, 0, 0, 0, "R1");
        cyc(0, 0, 0, 0, "R1");
        rst = 1'b0;
        cyc(0, 0, 0, 0, "R1");

        // R2: latch set/clear
        cyc(1, 0, 0, 0, "R2");
        cyc(2, 0, 0, 0, "R2");
        cyc(3, 1, 5, 0, "R3");            // latch clear: rejected
        // R3: lock 0, pin low ignored
        wp_n_i = 0;
        set_sr(0, 2);
        wp_n_i = 1;
        // R4: lock 1, pin high
        set_sr(1, 3);
        cyc(3, 1, 1, 0, "R4");            // latch clear: rejected
        set_sr(1, 4);
        // R6: pin falls after lock -> hardware mode
        wp_n_i = 0;
        cyc(0, 0, 0, 0, "R6");
        // R5: writes rejected even with latch
        cyc(1, 0, 0, 0, "R5");
        cyc(3, 0, 0, 0, "R5");
        // R7: only pin high exits
        cyc(2, 0, 0, 0, "R7");
        wp_n_i = 1;
        cyc(0, 0, 0, 0, "R7");
        set_sr(0, 0);
        // R6: lock set while pin already low
        wp_n_i = 0;
        set_sr(1, 0);
        cyc(0, 0, 0, 0, "R6");
        wp_n_i = 1;
        set_sr(0, 0);

        // R8 R9 R10: each selector value at the span boundary
        for (int bp = 0; bp < 8; bp++) begin
            set_sr(0, bp);
            if (bp == 0) bnd = 1 << AW;
            else if (bp == 7) bnd = 0;
            else bnd = (1 << AW) - (1 << (13 + bp));
            if (bnd > 0) begin
                cyc(1, 0, 0, 0, "R2");
                cyc(4, 0, 0, bnd - 1, "R9");
            end
            if (bnd < (1 << AW)) begin
                cyc(1, 0, 0, 0, "R2");
                cyc(5, 0, 0, bnd, "R8");
            end
            cyc(1, 0, 0, 0, "R2");
            cyc(6, 0, 0, 0, "R10");
            cyc(4, 0, 0, 0, "R11");       // latch clear
        end
        set_sr(0, 0);
        cyc(6, 0, 0, 0, "R11");

        // R12: random mix of one-hot commands, pin and data
        for (int i = 0; i < 4000; i++) begin
            int c, a;
            c = $urandom_range(0, 8);
            if (c > 6) c = 1;
            if ($urandom_range(0, 7) == 0) wp_n_i = ~wp_n_i;
            a = $urandom_range(0, (1 << AW) - 1);
            if ($urandom_range(0, 1) == 1) a = a | 32'hF0000;
            cyc(c, 1'($urandom_range(0, 1)), $urandom_range(0, 7), a, "R12");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule